// File: doc/BRIEF.md
# Constant-Bit-Rate Cell Payload Header Inserter

This block sits on the transmit side of a constant-bit-rate adaptation sublayer. It receives payload blocks of 47 bytes as a valid/ready byte stream with start and end markers. For each block it emits a 48-byte unit: one protected header byte, then the 47 payload bytes unchanged. The header carries a convergence indication bit, which upstream supplies with the first byte of the block, and a 3-bit sequence count that the block keeps itself. A 3-bit CRC and an even parity bit make the header self-checking, so a receiver can correct a single-bit error in it.

The block stores each incoming block in full before it starts the output unit. A block whose end marker comes early or late is therefore discarded as a whole and never reaches the output. Such a block raises a sticky length-error flag and does not use up a sequence number. While a unit is being sent, the input is held off. The output unit stalls under backpressure and neither loses nor repeats a byte.

Top module: `cbr_hdr_inserter`

## Requirements
- R1: Each accepted block produces exactly one output unit of 48 beats: the header beat carries `out_sop`=1, the last payload beat carries `out_eop`=1, and no other beat carries either marker.
- R2: The header byte layout is bit 7 = indication bit, bits 6:4 = sequence count, bits 3:1 = CRC, bit 0 = parity.
- R3: The CRC field is the remainder of the 4-bit value {indication, sequence count} multiplied by x^3 and divided by x^3 + x + 1 (binary 1011), with the most significant bit processed first.
- R4: The parity bit makes the count of ones over all 8 header bits even.
- R5: The sequence count is 0 in the first unit after reset and grows by one per emitted unit, modulo 8, so 7 is followed by 0.
- R6: The indication bit of a unit is the value of `in_ind` on the first byte of its block, and is 0 when `in_ind` is low then. Its value on the other bytes has no effect.
- R7: The 47 payload beats carry the block's input bytes in their input order, unchanged.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_sop` and `out_eop` hold their values into the next cycle.
- R9: `in_ready` is low in every cycle in which `out_valid` is high, and a byte is taken only in a cycle with `in_valid` and `in_ready` both high.
- R10: A block that ends before its 47th byte is dropped, sets `len_err`, and leaves the sequence count unchanged. A block ends early when `in_eop` arrives earlier, or when a byte with `in_sop` arrives after the first byte; in the second case that byte starts a new block.
- R11: A block whose 47th byte lacks `in_eop` is dropped up to and including the next byte with `in_eop`, sets `len_err`, and leaves the sequence count unchanged.
- R12: Reset leaves `in_ready`=1, `out_valid`=0 and `len_err`=0. Once set, `len_err` stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take an input byte |
| in_data | input | 8 | Input payload byte |
| in_sop | input | 1 | Marks the first byte of a block |
| in_eop | input | 1 | Marks the last byte of a block |
| in_ind | input | 1 | Convergence indication, sampled on the first byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream can take an output byte |
| out_data | output | 8 | Header or payload byte |
| out_sop | output | 1 | Marks the header beat |
| out_eop | output | 1 | Marks the last payload beat |
| len_err | output | 1 | Sticky flag for a dropped block of wrong length |

## Verification
The hardest state to reach from the ports is a wrong-length block that sits among good ones. It has to be dropped while the sequence count carries on with no gap, and only the header of the next good unit shows that the count did not move. The stimulus puts a short block, a block cut off by a new start marker, a one-byte block and an over-long block between good blocks. Meanwhile a reference queue predicts every output beat. Sixteen good blocks in a row, with the indication bit switched on for the second eight, take the counter through its wrap and produce all sixteen header values. Random `out_ready` stalls hold the unit under backpressure.

// File: rtl/cbr_hdr_pkg.sv
package cbr_hdr_pkg;

  // header field widths; the header byte is {ind, seq, crc, parity}
  localparam int unsigned SEQ_W     = 3;
  localparam int unsigned CRC_W     = 3;
  localparam int unsigned DATA_BITS = 1 + SEQ_W;
  localparam int unsigned HDR_W     = DATA_BITS + CRC_W + 1;
  localparam int unsigned BYTE_W    = 8;

  // generator x^3 + x + 1
  localparam logic [CRC_W:0] CRC_GEN = 4'b1011;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic {
    FILL_S = 1'b0,
    DROP_S = 1'b1
  } fill_st_e;

endpackage

// File: rtl/cbr_hdr_gen.sv
module cbr_hdr_gen
  import cbr_hdr_pkg::*;
(
  input  logic             ind_i,
  input  logic [SEQ_W-1:0] seq_i,
  output logic [HDR_W-1:0] hdr_o
);

  localparam int unsigned DIV_W = DATA_BITS + CRC_W;
  localparam logic [DIV_W-1:0] GEN_EXT = DIV_W'(CRC_GEN);

  // long division, one stage per data bit, MSB first
  logic [DATA_BITS:0][DIV_W-1:0] stage;
  logic [CRC_W-1:0]              crc;
  logic                          par;

  assign stage[0] = {ind_i, seq_i, {CRC_W{1'b0}}};

  generate
    for (genvar g = 0; g < DATA_BITS; g++) begin : g_div
      localparam int unsigned TOP = DIV_W - 1 - g;
      assign stage[g+1] = stage[g][TOP] ? (stage[g] ^ (GEN_EXT << (TOP - CRC_W)))
                                        : stage[g];
    end
  endgenerate

  assign crc   = stage[DATA_BITS][CRC_W-1:0];
  assign par   = ^{ind_i, seq_i, crc};
  assign hdr_o = {ind_i, seq_i, crc, par};

endmodule

// File: rtl/cbr_blk_buf.sv
module cbr_blk_buf
  import cbr_hdr_pkg::*;
#(
  parameter int unsigned DEPTH = 47,
  parameter int unsigned AW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  byte_t         wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output byte_t         rd_data_o
);

  byte_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      mem[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem[rd_addr_i];

endmodule

// File: rtl/cbr_in_ctrl.sv
module cbr_in_ctrl
  import cbr_hdr_pkg::*;
#(
  parameter int unsigned PAY_LEN = 47,
  parameter int unsigned CW      = $clog2(PAY_LEN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid_i,
  input  logic          in_sop_i,
  input  logic          in_eop_i,
  input  logic          in_ind_i,
  input  logic          busy_i,
  output logic          in_ready_o,
  output logic          wr_en_o,
  output logic [CW-1:0] wr_addr_o,
  output logic          blk_done_o,
  output logic          blk_ind_o,
  output logic          err_o
);

  localparam logic [CW-1:0] LAST = CW'(PAY_LEN - 1);

  fill_st_e      st_q, st_d;
  logic [CW-1:0] idx_q, idx_d;
  logic          ind_q, ind_d;
  logic          err_q, err_d;
  logic          accept;
  logic          start;
  logic [CW-1:0] pos;

  assign in_ready_o = ~busy_i;
  assign accept     = in_valid_i & ~busy_i;
  assign start      = (idx_q == '0) | in_sop_i;
  assign pos        = start ? '0 : idx_q;

  always_comb begin
    st_d       = st_q;
    idx_d      = idx_q;
    ind_d      = ind_q;
    err_d      = err_q;
    wr_en_o    = 1'b0;
    blk_done_o = 1'b0;
    if (accept) begin
      if (st_q == FILL_S) begin
        wr_en_o = 1'b1;
        if (start) begin
          ind_d = in_ind_i;
        end
        if (in_sop_i && (idx_q != '0)) begin
          err_d = 1'b1;                 // previous block cut short
        end
        if (pos == LAST) begin
          idx_d = '0;
          if (in_eop_i) begin
            blk_done_o = 1'b1;
          end else begin
            st_d  = DROP_S;
            err_d = 1'b1;
          end
        end else if (in_eop_i) begin
          idx_d = '0;
          err_d = 1'b1;
        end else begin
          idx_d = pos + CW'(1);
        end
      end else if (in_eop_i) begin
        st_d = FILL_S;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= FILL_S;
      idx_q <= '0;
      ind_q <= 1'b0;
    end else if (accept) begin
      st_q  <= st_d;
      idx_q <= idx_d;
      ind_q <= ind_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assign wr_addr_o = pos;
  assign blk_ind_o = ind_q;
  assign err_o     = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q); // R12

  AST_DONE_ON_EOP: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done_o |-> (in_valid_i && in_eop_i)); // R1

endmodule

// File: rtl/cbr_out_ctrl.sv
module cbr_out_ctrl
  import cbr_hdr_pkg::*;
#(
  parameter int unsigned PAY_LEN = 47,
  parameter int unsigned CW      = $clog2(PAY_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blk_done_i,
  input  logic             blk_ind_i,
  input  logic             out_ready_i,
  output logic             busy_o,
  output logic             sop_o,
  output logic             eop_o,
  output logic [CW-1:0]    rd_addr_o,
  output logic             hdr_ind_o,
  output logic [SEQ_W-1:0] seq_o
);

  localparam logic [CW-1:0] END_CNT = CW'(PAY_LEN);

  logic             busy_q, busy_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [SEQ_W-1:0] seq_q, seq_d;
  logic             ind_q, ind_d;
  logic             beat;
  logic             unit_end;
  logic             en;

  assign beat     = busy_q & out_ready_i;
  assign unit_end = beat & (cnt_q == END_CNT);
  assign en       = blk_done_i | beat;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    seq_d  = seq_q;
    ind_d  = ind_q;
    if (blk_done_i) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      ind_d  = blk_ind_i;
    end else if (beat) begin
      if (cnt_q == END_CNT) begin
        busy_d = 1'b0;
        seq_d  = seq_q + SEQ_W'(1);   // wraps modulo 8
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      seq_q  <= '0;
      ind_q  <= 1'b0;
    end else if (en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      seq_q  <= seq_d;
      ind_q  <= ind_d;
    end
  end

  assign busy_o    = busy_q;
  assign sop_o     = busy_q & (cnt_q == '0);
  assign eop_o     = busy_q & (cnt_q == END_CNT);
  assign rd_addr_o = (cnt_q == '0) ? '0 : cnt_q - CW'(1);
  assign hdr_ind_o = ind_q;
  assign seq_o     = seq_q;

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !out_ready_i) |=> (busy_q && $stable(cnt_q) && $stable(ind_q))); // R8

  AST_SEQ_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    !unit_end |=> $stable(seq_q)); // R5

endmodule

// File: rtl/cbr_hdr_inserter.sv
module cbr_hdr_inserter
  import cbr_hdr_pkg::*;
#(
  parameter int unsigned PAY_LEN = 47
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       in_sop,
  input  logic       in_eop,
  input  logic       in_ind,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_sop,
  output logic       out_eop,
  output logic       len_err
);

  localparam int unsigned CW = $clog2(PAY_LEN + 1);

  logic             wr_en;
  logic [CW-1:0]    wr_addr;
  logic [CW-1:0]    rd_addr;
  byte_t            rd_data;
  logic             blk_done;
  logic             blk_ind;
  logic             busy;
  logic             hdr_ind;
  logic [SEQ_W-1:0] seq;
  logic [HDR_W-1:0] hdr;

  cbr_in_ctrl #(.PAY_LEN(PAY_LEN), .CW(CW)) i_in (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid_i (in_valid),
    .in_sop_i   (in_sop),
    .in_eop_i   (in_eop),
    .in_ind_i   (in_ind),
    .busy_i     (busy),
    .in_ready_o (in_ready),
    .wr_en_o    (wr_en),
    .wr_addr_o  (wr_addr),
    .blk_done_o (blk_done),
    .blk_ind_o  (blk_ind),
    .err_o      (len_err)
  );

  cbr_blk_buf #(.DEPTH(PAY_LEN), .AW(CW)) i_buf (
    .clk       (clk),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (in_data),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  cbr_out_ctrl #(.PAY_LEN(PAY_LEN), .CW(CW)) i_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .blk_done_i  (blk_done),
    .blk_ind_i   (blk_ind),
    .out_ready_i (out_ready),
    .busy_o      (busy),
    .sop_o       (out_sop),
    .eop_o       (out_eop),
    .rd_addr_o   (rd_addr),
    .hdr_ind_o   (hdr_ind),
    .seq_o       (seq)
  );

  cbr_hdr_gen i_hdr (
    .ind_i (hdr_ind),
    .seq_i (seq),
    .hdr_o (hdr)
  );

  assign out_valid = busy;
  assign out_data  = out_sop ? hdr : rd_data;

  AST_NO_WRITE_WHILE_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !out_valid); // R9

  AST_HDR_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sop) |-> (^out_data == 1'b0)); // R4

  AST_UNIT_STARTS_HDR: assert property (@(posedge clk) disable iff (!rst_n)
    blk_done |=> (out_valid && out_sop)); // R1

  AST_DATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_eop))); // R8

endmodule

// File: tb/test_cbr_hdr_inserter.sv
`timescale 1ns/1ps
module test_cbr_hdr_inserter;

  localparam int PAY = 47;
  localparam time TCK = 8ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid, in_ready, in_sop, in_eop, in_ind;
  logic [7:0] in_data;
  logic       out_valid, out_ready, out_sop, out_eop, len_err;
  logic [7:0] out_data;

  always #(TCK/2) clk = ~clk;

  cbr_hdr_inserter i_cbr_hdr_inserter (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .in_ind(in_ind),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .len_err(len_err)
  );

  int         n_vec = 0;
  int         n_bad = 0;
  bit         ended = 0;
  logic [9:0] exp_q[$];          // {sop, eop, data}
  int         seq_m;
  int         blk_no = 0;
  bit         mon_on = 0;
  bit         stall_mode = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit         hold_pend = 0;
  logic [9:0] hold_val;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] expv);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  // reference header: CRC from x^k mod (x^3+x+1) residues, parity even
  function automatic logic [7:0] hdr_ref(input bit ind, input int seq);
    logic [3:0] d;
    logic [2:0] c;
    d = {ind, 3'(seq)};
    c = 3'b000;
    if (d[3]) c ^= 3'b101;
    if (d[2]) c ^= 3'b111;
    if (d[1]) c ^= 3'b110;
    if (d[0]) c ^= 3'b011;
    return {d, c, ^{d, c}};
  endfunction

  function automatic logic [7:0] pat(input int b, input int k);
    return 8'((b * 37 + k * 5 + 3) & 255);
  endfunction

  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(TCK * 150000);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  // downstream readiness, changed at the falling edge
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = stall_mode ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  // cycle-by-cycle compare against the expected-beat queue
  always @(negedge clk) begin
    logic [9:0] got;
    #1;
    if (rst_n && mon_on) begin
      got = {out_sop, out_eop, out_data};
      if (out_valid && in_ready)
        chk(1'b0, "R9 in_ready while sending", 1, 0);
      if (hold_pend)
        chk(out_valid && (got == hold_val), "R8 stalled beat held", got, hold_val);
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1 unexpected beat", got, 0);
        end else begin
          if (exp_q[0][9])
            chk(got == exp_q[0], "R2/R3/R4/R5/R6 header beat", got, exp_q[0]);
          else
            chk(got == exp_q[0], "R1/R7 payload beat", got, exp_q[0]);
          if (out_ready) void'(exp_q.pop_front());
        end
      end
      hold_pend = out_valid && !out_ready;
      hold_val  = got;
    end
  end

  task automatic do_reset;
    mon_on   = 0;
    rst_n    = 1'b0;
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; in_ind = 1'b0; in_data = '0;
    repeat (3) @(negedge clk);
    #2;
    chk(in_ready == 1'b1, "R12 reset in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R12 reset out_valid", out_valid, 0);
    chk(len_err == 1'b0, "R12 reset len_err", len_err, 0);
    @(negedge clk);
    rst_n     = 1'b1;
    seq_m     = 0;
    hold_pend = 0;
    exp_q.delete();
    mon_on    = 1;
  endtask

  // one byte, handshake completes at the edge after in_ready is seen high
  task automatic put(input logic [7:0] d, input bit s, input bit e, input bit ind);
    in_valid = 1'b1; in_data = d; in_sop = s; in_eop = e; in_ind = ind;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
  endtask

  task automatic send_block(input int n, input bit ind, input bit good,
                            input bit with_eop);
    for (int k = 0; k < n; k++) begin
      if (good && k == n - 1) begin
        exp_q.push_back({1'b1, 1'b0, hdr_ref(ind, seq_m)});
        for (int j = 0; j < PAY; j++)
          exp_q.push_back({1'b0, (j == PAY - 1), pat(blk_no, j)});
        seq_m = (seq_m + 1) % 8;
      end
      // in_ind is inverted after the first byte to show it is ignored (R6)
      put(pat(blk_no, k), (k == 0), with_eop && (k == n - 1), (k == 0) ? ind : ~ind);
    end
    blk_no++;
  endtask

  task automatic drain;
    for (int t = 0; t < 5000; t++) begin
      if (exp_q.size() == 0 && !out_valid) break;
      @(negedge clk);
    end
    chk(exp_q.size() == 0, "R1 all units emitted", exp_q.size(), 0);
  endtask

  initial begin
    do_reset();

    // R5 wrap and all 16 header values (R2 R3 R4 R6)
    for (int i = 0; i < 16; i++) send_block(PAY, (i >= 8), 1'b1, 1'b1);
    drain();
    chk(len_err == 1'b0, "R12 no error after good blocks", len_err, 0);

    // backpressure R8
    stall_mode = 1;
    for (int i = 0; i < 4; i++) send_block(PAY, i[0], 1'b1, 1'b1);

    // R10 early end marker, then good block must keep the count
    send_block(10, 1'b1, 1'b0, 1'b1);
    drain();
    chk(len_err == 1'b1, "R10 short block flagged", len_err, 1);
    send_block(PAY, 1'b1, 1'b1, 1'b1);

    // R10 block cut by a new start marker; the new block is good
    send_block(20, 1'b0, 1'b0, 1'b0);
    send_block(PAY, 1'b0, 1'b1, 1'b1);
    // R10 one-byte block
    send_block(1, 1'b1, 1'b0, 1'b1);
    send_block(PAY, 1'b1, 1'b1, 1'b1);
    drain();
    chk(len_err == 1'b1, "R12 flag sticky", len_err, 1);

    // R11 over-long block after a fresh reset
    stall_mode = 0;
    do_reset();
    send_block(PAY + 3, 1'b1, 1'b0, 1'b1);
    drain();
    chk(len_err == 1'b1, "R11 long block flagged", len_err, 1);
    send_block(PAY, 1'b0, 1'b1, 1'b1);   // header must carry count 0
    send_block(PAY, 1'b1, 1'b1, 1'b1);
    drain();

    finish_run();
  end

endmodule